// File: doc/BRIEF.md
# SD/MMC Command-Line Register Front End

This block sits between a 16-bit register bus and the one-bit command line of an SD/MMC card. Software writes a 32-bit argument as two halves and a response timeout, then writes the command word. That write starts the command. The block sends a 48-bit frame, most significant bit first, protected by CRC7. It then waits for the card to answer, collects a short (48-bit) or long (136-bit) response, and reports the result as one single-cycle pulse.

The command word holds three fields. The opcode sits in bits 5:0, the response type in bits 10:8, and the command class in bits 13:12. One special word, `0x0080`, sends no frame at all: it drives a run of initialization clocks with the line held high. Captured responses are read back from eight 16-bit response words. Each card-clock cycle here is one `clk` cycle.

Top module: `sdcmd_front`

## Requirements
- R1: Registers use byte offsets 0x00 for the command word, 0x04 for the argument low half, 0x08 for the argument high half, 0x18 for the timeout, and 0x40, 0x44, … 0x5C for response words 0–7. All of them are readable and all reset to 0. Any other offset reads 0.
- R2: Writing offset 0x00 while idle starts the command on the next cycle, with `cmd_oe` high. The frame is 0, 1, opcode[5:0], argument[31:0], CRC7, 1. The CRC7 uses generator x^7+x^3+1 over the first 40 bits. When `cmd_oe` is low, `cmd_out` is 1.
- R3: The command word exactly 0x0080 drives INIT_CLKS cycles of 1 with `cmd_oe` high and then pulses `eoc_pulse`. No frame is sent.
- R4: A response type (bits 10:8) of 0 pulses `eoc_pulse` during the end-bit cycle, and the block does not wait for a response.
- R5: Class code 0 (broadcast) expects no response, whatever the response type. The other class codes are 1 (broadcast with response), 2 (addressed) and 3 (addressed with data).
- R6: Any response type other than 0 and 2 receives a 48-bit response. Its bits 39:8 go to word 6 (low half) and word 7 (high half). Words 0–5 are left unchanged.
- R7: Response type 2 receives a 136-bit response. The 128 bits after the 8 header bits fill words 0–7, with the least significant 16 bits in word 0.
- R8: Wait cycles are counted from the first cycle after the end bit, starting at k=0. A start bit (0) is accepted in any wait cycle k ≤ timeout. Otherwise `cto_pulse` is raised and the response words are left unchanged.
- R9: With response type 1, a CRC7 mismatch in bits 7:1 over bits 47:8 raises `ccrc_pulse` instead of `eoc_pulse`, and the payload is still stored. Other short response types are not checked.
- R10: A command-word write while a command is in progress is ignored.
- R11: Each command ends with exactly one of the three pulses, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card clock per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input from the card |
| eoc_pulse | output | 1 | End-of-command pulse |
| cto_pulse | output | 1 | Command timeout pulse |
| ccrc_pulse | output | 1 | Response CRC error pulse |

## Verification
The hardest cases to reach are the timeout boundary and a corrupted response CRC. In both, the card model has to place its start bit in one exact wait cycle. The bench derives wait-cycle zero from the falling edge of `cmd_oe`. From there it drives the start bit at k = timeout, where it must be accepted, and at k = timeout+1, where it must time out. It also builds responses whose CRC is deliberately flipped. Command-word writes in the middle of a frame are injected from inside the frame-capture loop.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int RSP_WORDS  = 8;
  localparam logic [15:0] INIT_WORD = 16'h0080;
  localparam logic [2:0]  RT_NONE   = 3'd0;
  localparam logic [2:0]  RT_SHORT  = 3'd1;
  localparam logic [2:0]  RT_LONG   = 3'd2;

  typedef enum logic [1:0] {
    CL_BC = 2'd0, CL_BCR = 2'd1, CL_AC = 2'd2, CL_ADTC = 2'd3
  } cmd_class_e;

  typedef struct packed {
    logic expect_rsp;
    logic long_rsp;
    logic check_crc;
  } rsp_mode_t;

  // serial CRC7, generator x^7 + x^3 + 1, message MSB first
  function automatic logic [6:0] crc7_of40(input logic [39:0] msg);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = msg[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [5:0] op,
                                                         input logic [31:0] arg);
    logic [39:0] head;
    head = {2'b01, op, arg};
    return {head, crc7_of40(head), 1'b1};
  endfunction

  function automatic rsp_mode_t decode_mode(input logic [15:0] w);
    rsp_mode_t m;
    m.expect_rsp = (w[10:8] != RT_NONE) && (cmd_class_e'(w[13:12]) != CL_BC);
    m.long_rsp   = (w[10:8] == RT_LONG);
    m.check_crc  = (w[10:8] == RT_SHORT);
    return m;
  endfunction
endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [6:0]      addr,
  input  logic [15:0]     wdata,
  input  logic            busy,
  input  logic            rsp_load,
  input  logic            rsp_long,
  input  logic [127:0]    rsp_bits,
  output logic [15:0]     cmd_word,
  output logic [31:0]     arg,
  output logic [TO_W-1:0] cto,
  output logic            launch,
  output logic [15:0]     rdata
);
  localparam logic [6:0] A_CMD  = 7'h00;
  localparam logic [6:0] A_ARGL = 7'h04;
  localparam logic [6:0] A_ARGH = 7'h08;
  localparam logic [6:0] A_CTO  = 7'h18;

  logic [16*RSP_WORDS-1:0] rsp_flat;

  assign launch = wr_en && (addr == A_CMD) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      arg      <= '0;
      cto      <= '0;
    end else begin
      if (launch) cmd_word <= wdata;
      if (wr_en && addr == A_ARGL) arg[15:0]  <= wdata;
      if (wr_en && addr == A_ARGH) arg[31:16] <= wdata;
      if (wr_en && addr == A_CTO)  cto        <= wdata[TO_W-1:0];
    end
  end

  for (genvar g = 0; g < RSP_WORDS; g++) begin : g_rsp
    localparam bit IN_SHORT = (g >= RSP_WORDS - 2);
    localparam int SOFF = IN_SHORT ? 16 * (g - (RSP_WORDS - 2)) + 8 : 0;
    logic [15:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (rsp_load && rsp_long) word_q <= rsp_bits[16*g +: 16];
      else if (rsp_load && IN_SHORT) word_q <= rsp_bits[SOFF +: 16];
    end
    assign rsp_flat[16*g +: 16] = word_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CMD:   rdata = cmd_word;
      A_ARGL:  rdata = arg[15:0];
      A_ARGH:  rdata = arg[31:16];
      A_CTO:   rdata = 16'(cto);
      default: if (addr[6:5] == 2'b10 && addr[1:0] == 2'b00)
                 rdata = rsp_flat[{addr[4:2], 4'b0000} +: 16];
    endcase
  end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
#(
  parameter int INIT_CLKS = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [15:0] cmd_wdata,
  input  logic [31:0] arg,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        tx_last,
  output logic        tx_init
);
  localparam int MAXB = (INIT_CLKS > FRAME_BITS) ? INIT_CLKS : FRAME_BITS;
  localparam int CW   = $clog2(MAXB + 1);

  logic                  busy_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [CW-1:0]         cnt_q;
  logic                  is_init;

  assign is_init = (cmd_wdata == INIT_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sh_q    <= '1;
      cnt_q   <= '0;
      tx_init <= 1'b0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      tx_init <= is_init;
      sh_q    <= is_init ? '1 : build_frame(cmd_wdata[5:0], arg);
      cnt_q   <= is_init ? CW'(INIT_CLKS - 1) : CW'(FRAME_BITS - 1);
    end else if (busy_q) begin
      sh_q <= {sh_q[FRAME_BITS-2:0], 1'b1};
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign tx_last = busy_q && (cnt_q == '0);
  assign cmd_oe  = busy_q;
  assign cmd_out = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            long_rsp,
  input  logic            check_crc,
  input  logic [TO_W-1:0] cto,
  input  logic            cmd_in,
  output logic            rx_busy,
  output logic            rx_wait,
  output logic            rx_done,
  output logic            rx_timeout,
  output logic            rx_crc_bad,
  output logic [127:0]    rx_bits
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RECV} rx_state_e;

  rx_state_e            st_q;
  logic [TO_W-1:0]      wcnt_q;
  logic [7:0]           bcnt_q;
  logic [LONG_BITS-1:0] sh_q;
  logic                 long_q, chk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; wcnt_q <= '0; bcnt_q <= '0; sh_q <= '0;
      long_q <= 1'b0; chk_q <= 1'b0; rx_done <= 1'b0; rx_timeout <= 1'b0;
    end else begin
      rx_done    <= 1'b0;
      rx_timeout <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_WAIT;
          wcnt_q <= '0;
          long_q <= long_rsp;
          chk_q  <= check_crc;
        end
        S_WAIT: begin
          if (!cmd_in) begin
            st_q   <= S_RECV;
            sh_q   <= {sh_q[LONG_BITS-2:0], 1'b0};
            bcnt_q <= long_q ? 8'(LONG_BITS - 1) : 8'(FRAME_BITS - 1);
          end else if (wcnt_q == cto) begin
            st_q       <= S_IDLE;
            rx_timeout <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: begin
          sh_q   <= {sh_q[LONG_BITS-2:0], cmd_in};
          bcnt_q <= bcnt_q - 1'b1;
          if (bcnt_q == 8'd1) begin
            st_q    <= S_IDLE;
            rx_done <= 1'b1;
          end
        end
      endcase
    end
  end

  assign rx_busy    = (st_q != S_IDLE);
  assign rx_wait    = (st_q == S_WAIT);
  assign rx_crc_bad = rx_done && chk_q && (crc7_of40(sh_q[47:8]) != sh_q[7:1]);
  assign rx_bits    = sh_q[127:0];
endmodule

// File: rtl/sdcmd_front.sv
module sdcmd_front
  import sdcmd_pkg::*;
#(
  parameter int TO_W      = 16,
  parameter int INIT_CLKS = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [6:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  output logic        eoc_pulse,
  output logic        cto_pulse,
  output logic        ccrc_pulse
);
  logic [15:0]     cmd_word;
  logic [31:0]     arg;
  logic [TO_W-1:0] cto;
  logic            launch, busy;
  logic            tx_last, tx_init;
  logic            rx_busy, rx_wait, rx_done, rx_timeout, rx_crc_bad, rx_start;
  logic [127:0]    rx_bits;
  rsp_mode_t       mode;

  assign mode     = decode_mode(cmd_word);
  assign busy     = cmd_oe || rx_busy;
  assign rx_start = tx_last && !tx_init && mode.expect_rsp;

  sdcmd_regs #(.TO_W(TO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .rsp_load(rx_done), .rsp_long(mode.long_rsp), .rsp_bits(rx_bits),
    .cmd_word(cmd_word), .arg(arg), .cto(cto), .launch(launch), .rdata(reg_rdata)
  );

  sdcmd_tx #(.INIT_CLKS(INIT_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd_wdata(reg_wdata), .arg(arg),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .tx_last(tx_last), .tx_init(tx_init)
  );

  sdcmd_rx #(.TO_W(TO_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .long_rsp(mode.long_rsp),
    .check_crc(mode.check_crc), .cto(cto), .cmd_in(cmd_in), .rx_busy(rx_busy),
    .rx_wait(rx_wait), .rx_done(rx_done), .rx_timeout(rx_timeout),
    .rx_crc_bad(rx_crc_bad), .rx_bits(rx_bits)
  );

  assign eoc_pulse  = (tx_last && (tx_init || !mode.expect_rsp)) || (rx_done && !rx_crc_bad);
  assign cto_pulse  = rx_timeout;
  assign ccrc_pulse = rx_crc_bad;
endmodule

// File: rtl/sdcmd_front_chk.sv
module sdcmd_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [6:0]  reg_addr,
  input logic        cmd_out,
  input logic        cmd_oe,
  input logic        eoc_pulse,
  input logic        cto_pulse,
  input logic        ccrc_pulse,
  input logic        launch,
  input logic        tx_init,
  input logic        busy,
  input logic [15:0] cmd_word
);
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoc_pulse, cto_pulse, ccrc_pulse}));

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);

  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (cmd_oe && (tx_init || !cmd_out)));

  p_init_all_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oe && tx_init) |-> cmd_out);

  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 7'h00 && busy) |=> $stable(cmd_word));

  p_release_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoc_pulse || cto_pulse || ccrc_pulse) && !launch) |=> !cmd_oe);
endmodule

bind sdcmd_front sdcmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_out(cmd_out), .cmd_oe(cmd_oe), .eoc_pulse(eoc_pulse),
  .cto_pulse(cto_pulse), .ccrc_pulse(ccrc_pulse), .launch(launch),
  .tx_init(tx_init), .busy(busy), .cmd_word(cmd_word)
);

// File: tb/sdcmd_front_test.sv
module sdcmd_front_test;
  localparam int INIT_N = 80;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, cmd_in = 1'b1;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic cmd_out, cmd_oe, eoc_pulse, cto_pulse, ccrc_pulse;

  int n_cmp = 0, n_bad = 0;
  int r_ntx, r_eoc, r_cto, r_ccrc;
  logic [47:0] r_cap;
  logic r_ones;
  logic [15:0] m_rsp [8];

  sdcmd_front uut (.*);

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // remainder of polynomial long division, generator 1000_1001
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'b1000_1001;
    return r[6:0];
  endfunction

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic check_rsp(input string tag);
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(7'(8'h40 + 4 * i), v);
      check(tag, v, m_rsp[i]);
    end
  endtask

  task automatic run(input logic [15:0] cw, input logic [31:0] arg, input logic [15:0] cto,
                     input int delay, input logic long_r, input logic corrupt,
                     input logic [127:0] pay, input logic busy_wr, input logic [15:0] busy_cw);
    logic [135:0] rv;
    int rlen, k, post;
    logic seen;
    if (long_r) begin rv = {8'b0011_1111, pay}; rlen = 136; end
    else begin
      rv = {2'b00, cw[5:0], pay[31:0], ref_crc({2'b00, cw[5:0], pay[31:0]}) ^ {6'b0, corrupt},
            1'b1, 88'b0};
      rlen = 48;
    end
    wr(7'h04, arg[15:0]); wr(7'h08, arg[31:16]); wr(7'h18, cto);
    wr(7'h00, cw);
    r_ntx = 0; r_eoc = 0; r_cto = 0; r_ccrc = 0; r_cap = '0; r_ones = 1'b1;
    k = -1; post = 0; seen = 1'b0;
    for (int it = 0; it < 600; it++) begin
      if (cmd_oe) begin
        r_ntx++; r_cap = {r_cap[46:0], cmd_out};
        if (!cmd_out) r_ones = 1'b0;
      end
      if (eoc_pulse) r_eoc++;
      if (cto_pulse) r_cto++;
      if (ccrc_pulse) r_ccrc++;
      if (eoc_pulse || cto_pulse || ccrc_pulse) seen = 1'b1;
      if (busy_wr && it == 5) begin reg_wr = 1'b1; reg_addr = 7'h00; reg_wdata = busy_cw; end
      else reg_wr = 1'b0;
      if (k < 0 && !cmd_oe && r_ntx > 0) k = 0;
      else if (k >= 0) k++;
      cmd_in = 1'b1;
      if (delay >= 0 && !seen && k >= delay && (k - delay) < rlen) cmd_in = rv[135 - (k - delay)];
      if (seen) post++;
      if (post >= 4) break;
      @(negedge clk);
    end
    reg_wr = 1'b0; cmd_in = 1'b1;
  endtask

  function automatic logic [47:0] exp_frame(input logic [5:0] op, input logic [31:0] arg);
    return {2'b01, op, arg, ref_crc({2'b01, op, arg}), 1'b1};
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [31:0] p32;
    logic [127:0] p128;
    for (int i = 0; i < 8; i++) m_rsp[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 reset oe", cmd_oe, 0);
    check("R2 idle line", cmd_out, 1);
    rd(7'h00, v); check("R1 reset cmd", v, 0);
    rd(7'h04, v); check("R1 reset argl", v, 0);
    rd(7'h08, v); check("R1 reset argh", v, 0);
    rd(7'h18, v); check("R1 reset cto", v, 0);
    check_rsp("R1 reset rsp");
    // R1 readback
    wr(7'h04, 16'hA5C3); wr(7'h08, 16'h1E2D); wr(7'h18, 16'h00C8);
    rd(7'h04, v); check("R1 argl", v, 16'hA5C3);
    rd(7'h08, v); check("R1 argh", v, 16'h1E2D);
    rd(7'h18, v); check("R1 cto", v, 16'h00C8);
    rd(7'h10, v); check("R1 unmapped", v, 0);
    // R2 / R4 frame sweep without response
    for (int o = 0; o < 64; o += 7) begin
      logic [31:0] a;
      a = 32'h9E37_79B9 * (o + 1);
      run({2'b00, 2'd2, 4'd0, 2'b00, 6'(o)}, a, 16'd4, -1, 1'b0, 1'b0, '0, 1'b0, '0);
      check("R2 frame bits", r_cap, exp_frame(6'(o), a));
      check("R2 frame len", r_ntx, 48);
      check("R4 eoc", r_eoc, 1);
      check("R11 no other pulse", r_cto + r_ccrc, 0);
      check("R1 cmd readback", uut.reg_rdata === reg_rdata, 1);
    end
    // R5 broadcast class with nonzero response type
    run({2'b00, 2'd0, 1'b0, 3'd1, 2'b00, 6'd2}, 32'h0, 16'd3, -1, 1'b0, 1'b0, '0, 1'b0, '0);
    check("R5 eoc", r_eoc, 1);
    check("R5 no timeout", r_cto, 0);
    // R6 / R8 short responses, start delay up to timeout
    for (int i = 0; i < 6; i++) begin
      logic [15:0] cto;
      cto = 16'(i * 3);
      p32 = 32'h1234_5678 ^ (32'h0F1E_2D3C * (i + 1));
      run({2'b00, 2'd2, 1'b0, 3'd1, 2'b00, 6'(13 + i)}, 32'h0000_1000 * i, cto,
          (i % 2 == 0) ? i * 3 : i, 1'b0, 1'b0, {96'b0, p32}, 1'b0, '0);
      m_rsp[6] = p32[15:0]; m_rsp[7] = p32[31:16];
      check("R6 short eoc", r_eoc, 1);
      check("R8 accepted at k<=cto", r_cto, 0);
      check_rsp("R6 short words");
    end
    // R8 timeout one cycle past the limit
    run({2'b00, 2'd2, 1'b0, 3'd1, 2'b00, 6'd7}, 32'h0, 16'd5, 6, 1'b0, 1'b0, 128'hDEAD_BEEF, 1'b0, '0);
    check("R8 timeout pulse", r_cto, 1);
    check("R8 no eoc", r_eoc, 0);
    check_rsp("R8 rsp unchanged");
    // R9 bad CRC on checked type
    p32 = 32'hCAFE_F00D;
    run({2'b00, 2'd2, 1'b0, 3'd1, 2'b00, 6'd17}, 32'h55, 16'd8, 2, 1'b0, 1'b1, {96'b0, p32}, 1'b0, '0);
    m_rsp[6] = p32[15:0]; m_rsp[7] = p32[31:16];
    check("R9 ccrc pulse", r_ccrc, 1);
    check("R9 no eoc", r_eoc, 0);
    check_rsp("R9 payload kept");
    // R9 bad CRC on unchecked short type 3
    p32 = 32'h0BAD_C0DE;
    run({2'b00, 2'd1, 1'b0, 3'd3, 2'b00, 6'd41}, 32'h0, 16'd8, 1, 1'b0, 1'b1, {96'b0, p32}, 1'b0, '0);
    m_rsp[6] = p32[15:0]; m_rsp[7] = p32[31:16];
    check("R9 unchecked eoc", r_eoc, 1);
    check("R9 unchecked no ccrc", r_ccrc, 0);
    check_rsp("R6 type3 words");
    // R7 long responses
    for (int i = 0; i < 2; i++) begin
      p128 = {4{32'h8765_4321 ^ (32'h1357_9BDF * (i + 3))}} ^ {32'h0, 32'h1, 32'h2, 32'h3};
      run({2'b00, 2'd1, 1'b0, 3'd2, 2'b00, 6'd9}, 32'h0, 16'd20, 3 + i, 1'b1, 1'b0, p128, 1'b0, '0);
      for (int w = 0; w < 8; w++) m_rsp[w] = p128[16*w +: 16];
      check("R7 long eoc", r_eoc, 1);
      check_rsp("R7 long words");
    end
    // R3 initialization clocks
    run(16'h0080, 32'h0, 16'd2, -1, 1'b0, 1'b0, '0, 1'b0, '0);
    check("R3 init length", r_ntx, INIT_N);
    check("R3 init all ones", r_ones, 1);
    check("R3 init eoc", r_eoc, 1);
    // R10 command write while busy
    run({2'b00, 2'd2, 4'd0, 2'b00, 6'd5}, 32'h7777_0001, 16'd2, -1, 1'b0, 1'b0, '0, 1'b1,
        {2'b00, 2'd2, 4'd0, 2'b00, 6'd33});
    rd(7'h00, v);
    check("R10 cmd unchanged", v, {2'b00, 2'd2, 4'd0, 2'b00, 6'd5});
    check("R10 single frame", r_ntx, 48);
    check("R10 frame intact", r_cap, exp_frame(6'd5, 32'h7777_0001));
    check("R11 single eoc", r_eoc, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule